// File: doc/BRIEF.md
# Keyed Operating-Mode Request Register

This block lets software ask for a new device operating mode through a small 32-bit register bus. Changing the requested mode takes two writes to the control register that name the same mode: the first carries an opening key, the second the bitwise inverse of that key. Only when the pair completes does the block load its target-mode register and raise a one-cycle request pulse for the mode sequencer downstream. A single stray write therefore cannot change the operating mode.

A second register holds a per-mode enable mask, so optional modes can be switched off. A completed request for a reserved code or a disabled mode is refused and sets a sticky error flag in a status register. Two hardware inputs override software. A safe-mode request forces the SAFE code. A wake event, taken while the target is one of the two low-power modes, restores the last RUN mode that software selected.

Top module: `kmr_mode_request`

## Requirements
- R1: After synchronous reset the target mode is DRUN (code 3) and `req_valid` is 0. The mask reads 0x0000001D and the status register reads 0.
- R2: Two writes to the control register (offset 0) complete a request. The first carries key 0x5AF0 in bits 31:16 and a mode code in bits 3:0. The second carries key 0xA50F and the same mode. One cycle after the second write, `tgt_mode` holds that code and `req_valid` is high for exactly one cycle.
- R3: A control write whose key is neither 0x5AF0 nor 0xA50F changes nothing. A write of 0xA50F with no pending opening write also changes nothing, and neither write starts a sequence.
- R4: While a sequence is pending, any control write other than 0xA50F with the same mode code cancels it. A following 0xA50F write then completes nothing.
- R5: A read of the control register returns 0xA50F in bits 31:16 and the target mode in bits 3:0, with zeros elsewhere.
- R6: The mask register (offset 4) has one enable bit per mode code, bit n enabling code n. Bits 1, 5, 6, 7, 8 and 10 are writable. Bits 0, 2, 3 and 4 always read 1. Every other bit reads 0.
- R7: A completed request for a reserved code (9, 11 to 15), or for a code whose mask bit is 0, leaves the target unchanged and gives no pulse. It sets status bit 0 (offset 8).
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: While `hw_safe_req` is high, the target is loaded with SAFE (code 2) and `req_valid` pulses in the next cycle.
- R10: `hw_wake_evt` while the target is HALT0 (8) or STOP0 (10) loads the last RUN mode (codes 4 to 7) that a software request selected, RUN0 after reset, and pulses `req_valid`. In any other target mode it has no effect.
- R11: Priority is safe request, then wake, then software completion. A software completion in the same cycle as an active override is discarded without setting status, and any override cancels a pending sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_safe_req | input | 1 | Hardware request to enter SAFE |
| hw_wake_evt | input | 1 | Hardware exit event from a low-power mode |
| tgt_mode | output | 4 | Currently requested target mode |
| req_valid | output | 1 | One-cycle pulse when `tgt_mode` is newly loaded |

## Verification
The hardware overrides and the closing software write can land on the same clock edge. The bench provokes this by arming a sequence and then presenting the inverted-key write together with `hw_safe_req`, and in a second case together with `hw_wake_evt` while the target is a low-power mode. It judges the result by three things: the target must show the override value and not the software mode, the status flag must stay clear, and a repeated inverted-key write must complete nothing, which proves the sequence was cancelled.

// File: rtl/kmr_pkg.sv
package kmr_pkg;

    localparam int MODE_W  = 4;
    localparam int KEY_W   = 16;
    localparam int MASK_W  = 16;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t M_RESET = 4'd0;
    localparam mode_t M_TEST  = 4'd1;
    localparam mode_t M_SAFE  = 4'd2;
    localparam mode_t M_DRUN  = 4'd3;
    localparam mode_t M_RUN0  = 4'd4;
    localparam mode_t M_RUN3  = 4'd7;
    localparam mode_t M_HALT0 = 4'd8;
    localparam mode_t M_STOP0 = 4'd10;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5AF0;
    localparam logic [KEY_W-1:0] KEY_CLOSE = ~KEY_OPEN;

    // enable bits that are fixed at one, and bits software may change
    localparam logic [MASK_W-1:0] MASK_FIXED    = 16'h001D;
    localparam logic [MASK_W-1:0] MASK_WRITABLE = 16'h05E2;

    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_e;

    typedef enum logic [1:0] {SRC_NONE, SRC_SAFE, SRC_WAKE, SRC_SW} load_src_e;

    typedef struct packed {
        logic  done;
        mode_t mode;
    } sw_req_t;

    function automatic logic code_legal(input mode_t m);
        return (m <= M_HALT0) || (m == M_STOP0);
    endfunction

    function automatic logic code_is_run(input mode_t m);
        return (m >= M_RUN0) && (m <= M_RUN3);
    endfunction

    function automatic logic code_is_lowpower(input mode_t m);
        return (m == M_HALT0) || (m == M_STOP0);
    endfunction

endpackage

// File: rtl/kmr_key_seq.sv
module kmr_key_seq
    import kmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [KEY_W-1:0] key,
    input  mode_t            mode,
    input  logic             hw_abort,
    output sw_req_t          req
);

    seq_state_e state;
    mode_t      held_mode;

    always_comb begin
        req.done = wr_ctrl && (state == SEQ_ARMED) && (key == KEY_CLOSE) && (mode == held_mode);
        req.mode = held_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            held_mode <= M_RESET;
        end else if (hw_abort) begin
            state <= SEQ_IDLE;
        end else if (wr_ctrl) begin
            if (state == SEQ_ARMED) begin
                state <= SEQ_IDLE;
            end else if (key == KEY_OPEN) begin
                state     <= SEQ_ARMED;
                held_mode <= mode;
            end
        end
    end

    // R4: a pending sequence never survives the next control write
    a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && state == SEQ_ARMED) |=> (state == SEQ_IDLE));

    // R3: only the opening key can start a sequence
    a_r3_no_false_arm: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && state == SEQ_IDLE && key != KEY_OPEN) |=> (state == SEQ_IDLE));

    // R11: an override cancels whatever was pending
    a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
        hw_abort |=> (state == SEQ_IDLE));

endmodule

// File: rtl/kmr_mode_mask.sv
module kmr_mode_mask #(
    parameter int              W        = 16,
    parameter logic [W-1:0]    FIXED    = 16'h001D,
    parameter logic [W-1:0]    WRITABLE = 16'h05E2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (WRITABLE[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)     bit_q <= FIXED[i];
                else if (wr) bit_q <= wdata[i];
            end
            assign mask[i] = bit_q;
        end else begin : g_const
            assign mask[i] = FIXED[i];
        end
    end

    // R6: writable bits take the written value, nothing else moves
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((mask & WRITABLE) == ($past(wdata) & WRITABLE)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mask));

endmodule

// File: rtl/kmr_target.sv
module kmr_target
    import kmr_pkg::*;
#(
    parameter mode_t RESET_MODE = M_DRUN
) (
    input  logic              clk,
    input  logic              rst,
    input  sw_req_t           sw,
    input  logic [MASK_W-1:0] mask,
    input  logic              hw_safe,
    input  logic              hw_wake,
    input  logic              stat_wr,
    input  logic              stat_clr,
    output mode_t             tgt,
    output logic              req_valid,
    output logic              invalid_flag
);

    load_src_e src;
    logic      sw_ok;
    mode_t     last_run;

    always_comb begin
        if (hw_safe)                               src = SRC_SAFE;
        else if (hw_wake && code_is_lowpower(tgt)) src = SRC_WAKE;
        else if (sw.done)                          src = SRC_SW;
        else                                       src = SRC_NONE;
        sw_ok = code_legal(sw.mode) && mask[sw.mode];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt          <= RESET_MODE;
            last_run     <= M_RUN0;
            req_valid    <= 1'b0;
            invalid_flag <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            case (src)
                SRC_SAFE: begin
                    tgt       <= M_SAFE;
                    req_valid <= 1'b1;
                end
                SRC_WAKE: begin
                    tgt       <= last_run;
                    req_valid <= 1'b1;
                end
                SRC_SW: begin
                    if (sw_ok) begin
                        tgt       <= sw.mode;
                        req_valid <= 1'b1;
                        if (code_is_run(sw.mode)) last_run <= sw.mode;
                    end
                end
                default: ;
            endcase
            if (src == SRC_SW && !sw_ok)   invalid_flag <= 1'b1;
            else if (stat_wr && stat_clr)  invalid_flag <= 1'b0;
        end
    end

    // R2: the target never changes silently
    a_r2_change_pulses: assert property (@(posedge clk) disable iff (rst)
        (tgt != $past(tgt)) |-> req_valid);

    // R7: a pulse never announces a reserved code
    a_r7_pulse_legal: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> code_legal(tgt));

    // R7: a refused request raises the flag without a pulse
    a_r7_refuse_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(invalid_flag) |-> !req_valid);

    // R9: safe request wins and is announced
    a_r9_safe_load: assert property (@(posedge clk) disable iff (rst)
        hw_safe |=> (tgt == M_SAFE) && req_valid);

    // R10: wake outside a low-power target does nothing
    a_r10_wake_idle: assert property (@(posedge clk) disable iff (rst)
        (hw_wake && !hw_safe && !code_is_lowpower(tgt) && !sw.done) |=> ($stable(tgt) && !req_valid));

endmodule

// File: rtl/kmr_mode_request.sv
module kmr_mode_request
    import kmr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 4'h0,
    parameter logic [ADDR_W-1:0] OFS_MASK = 4'h4,
    parameter logic [ADDR_W-1:0] OFS_STAT = 4'h8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hw_safe_req,
    input  logic              hw_wake_evt,
    output logic [MODE_W-1:0] tgt_mode,
    output logic              req_valid
);

    localparam int PAD_W = 32 - KEY_W - MODE_W;

    logic              wr_ctrl, wr_mask, wr_stat;
    logic              hw_abort;
    logic              invalid_flag;
    logic [MASK_W-1:0] mask;
    sw_req_t           sw_req;
    mode_t             tgt;
    logic              unused_wdata;

    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign wr_mask = bus_we && (bus_addr == OFS_MASK);
    assign wr_stat = bus_we && (bus_addr == OFS_STAT);
    assign hw_abort = hw_safe_req || (hw_wake_evt && code_is_lowpower(tgt));
    assign unused_wdata = ^bus_wdata[KEY_W-1:MODE_W];

    kmr_key_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .key      (bus_wdata[31:32-KEY_W]),
        .mode     (bus_wdata[MODE_W-1:0]),
        .hw_abort (hw_abort),
        .req      (sw_req)
    );

    kmr_mode_mask #(
        .W        (MASK_W),
        .FIXED    (MASK_FIXED),
        .WRITABLE (MASK_WRITABLE)
    ) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_mask),
        .wdata (bus_wdata[MASK_W-1:0]),
        .mask  (mask)
    );

    kmr_target #(
        .RESET_MODE (M_DRUN)
    ) u_tgt (
        .clk          (clk),
        .rst          (rst),
        .sw           (sw_req),
        .mask         (mask),
        .hw_safe      (hw_safe_req),
        .hw_wake      (hw_wake_evt),
        .stat_wr      (wr_stat),
        .stat_clr     (bus_wdata[0]),
        .tgt          (tgt),
        .req_valid    (req_valid),
        .invalid_flag (invalid_flag)
    );

    always_comb begin
        if (bus_addr == OFS_CTRL)      bus_rdata = {KEY_CLOSE, {PAD_W{1'b0}}, tgt};
        else if (bus_addr == OFS_MASK) bus_rdata = {{(32-MASK_W){1'b0}}, mask};
        else if (bus_addr == OFS_STAT) bus_rdata = {31'b0, invalid_flag};
        else                           bus_rdata = 32'b0;
    end

    assign tgt_mode = tgt;

    // R8: writing zero never clears a raised flag
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (invalid_flag && wr_stat && !bus_wdata[0]) |=> invalid_flag);

endmodule

// File: tb/sim_kmr_mode_request.sv
module sim_kmr_mode_request;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        hw_safe, hw_wake;
    logic [3:0]  tgt_mode;
    logic        req_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0]  exp_tgt;
    logic [3:0]  exp_last;
    logic [15:0] exp_mask;
    logic        done = 1'b0;

    localparam logic [15:0] K1 = 16'h5AF0;
    localparam logic [15:0] K2 = 16'hA50F;

    always #10 clk = ~clk;

    kmr_mode_request u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_safe_req(hw_safe), .hw_wake_evt(hw_wake),
        .tgt_mode(tgt_mode), .req_valid(req_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic s, input logic w);
        bus_we = we; bus_addr = a; bus_wdata = d; hw_safe = s; hw_wake = w;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; hw_safe = 1'b0; hw_wake = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic legal(input logic [3:0] c);
        return (c <= 4'd8) || (c == 4'd10);
    endfunction

    // full two-write request with model update and checks (R2, R7)
    task automatic swreq(input logic [3:0] c);
        logic ok;
        logic [31:0] r;
        ok = legal(c) && exp_mask[c];
        step(1'b1, 4'h0, {K1, 12'h0, c}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, c}, 1'b0, 1'b0);
        if (ok) begin
            exp_tgt = c;
            if (c >= 4'd4 && c <= 4'd7) exp_last = c;
        end
        check(ok ? "R2 pulse" : "R7 no pulse", {31'b0, req_valid}, {31'b0, ok});
        check(ok ? "R2 target" : "R7 target kept", {28'b0, tgt_mode}, {28'b0, exp_tgt});
        rd(4'h8, r);
        check("R7 status", r, {31'b0, !ok});
        if (!ok) step(1'b1, 4'h8, 32'h1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; bus_we = 0; bus_addr = 0; bus_wdata = 0; hw_safe = 0; hw_wake = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_tgt = 4'd3; exp_last = 4'd4; exp_mask = 16'h001D;

        // R1 reset state
        check("R1 target", {28'b0, tgt_mode}, 32'd3);
        check("R1 pulse", {31'b0, req_valid}, 32'd0);
        rd(4'h4, r); check("R1 mask", r, 32'h1D);
        rd(4'h8, r); check("R1 status", r, 32'h0);
        rd(4'h0, r); check("R5 ctrl read", r, 32'hA50F0003);

        // R6 mask write behaviour
        step(1'b1, 4'h4, 32'hFFFFFFFF, 1'b0, 1'b0);
        rd(4'h4, r); check("R6 all ones", r, 32'h05FF);
        step(1'b1, 4'h4, 32'h0, 1'b0, 1'b0);
        rd(4'h4, r); check("R6 all zero", r, 32'h001D);

        // sweep every writable mask pattern against every code
        for (int p = 0; p < 64; p++) begin
            logic [15:0] m;
            m = 16'h0;
            m[1] = p[0]; m[5] = p[1]; m[6] = p[2]; m[7] = p[3]; m[8] = p[4]; m[10] = p[5];
            step(1'b1, 4'h4, {16'hFFFF, m}, 1'b0, 1'b0);
            exp_mask = m | 16'h001D;
            rd(4'h4, r); check("R6 readback", r, {16'h0, exp_mask});
            for (int c = 0; c < 16; c++) swreq(4'(c));
        end
        rd(4'h0, r); check("R5 ctrl read", r, {16'hA50F, 12'h0, exp_tgt});

        // R8 write zero keeps, write one clears
        swreq(4'd4);
        step(1'b1, 4'h0, {K1, 12'h0, 4'd9}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd9}, 1'b0, 1'b0);
        rd(4'h8, r); check("R8 set", r, 32'h1);
        step(1'b1, 4'h8, 32'h0, 1'b0, 1'b0);
        rd(4'h8, r); check("R8 zero keeps", r, 32'h1);
        step(1'b1, 4'h8, 32'h1, 1'b0, 1'b0);
        rd(4'h8, r); check("R8 one clears", r, 32'h0);

        // R3 foreign key, lone closing key
        step(1'b1, 4'h0, {16'h1234, 12'h0, 4'd5}, 1'b0, 1'b0);
        check("R3 foreign key", {31'b0, req_valid}, 32'd0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd5}, 1'b0, 1'b0);
        check("R3 lone close pulse", {31'b0, req_valid}, 32'd0);
        check("R3 lone close target", {28'b0, tgt_mode}, {28'b0, exp_tgt});

        // R4 mismatched mode, repeated opening key
        step(1'b1, 4'h0, {K1, 12'h0, 4'd5}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd6}, 1'b0, 1'b0);
        check("R4 mode mismatch", {31'b0, req_valid}, 32'd0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd5}, 1'b0, 1'b0);
        check("R4 after cancel", {31'b0, req_valid}, 32'd0);
        step(1'b1, 4'h0, {K1, 12'h0, 4'd5}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K1, 12'h0, 4'd5}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd5}, 1'b0, 1'b0);
        check("R4 double open", {31'b0, req_valid}, 32'd0);
        check("R4 target kept", {28'b0, tgt_mode}, {28'b0, exp_tgt});

        // R10 wake from each low-power mode
        swreq(4'd6);
        swreq(4'd8);
        step(1'b0, 4'h0, 32'h0, 1'b0, 1'b1);
        check("R10 wake halt target", {28'b0, tgt_mode}, 32'd6);
        check("R10 wake halt pulse", {31'b0, req_valid}, 32'd1);
        step(1'b0, 4'h0, 32'h0, 1'b0, 1'b1);
        check("R10 wake ignored", {31'b0, req_valid}, 32'd0);
        check("R10 wake ignored target", {28'b0, tgt_mode}, 32'd6);
        exp_tgt = 4'd6;
        swreq(4'd10);
        step(1'b0, 4'h0, 32'h0, 1'b0, 1'b1);
        check("R10 wake stop target", {28'b0, tgt_mode}, 32'd6);
        exp_tgt = 4'd6;

        // R9 safe alone
        step(1'b0, 4'h0, 32'h0, 1'b1, 1'b0);
        check("R9 safe target", {28'b0, tgt_mode}, 32'd2);
        check("R9 safe pulse", {31'b0, req_valid}, 32'd1);
        exp_tgt = 4'd2;

        // R11 safe + wake + closing write in one cycle
        swreq(4'd10);
        step(1'b1, 4'h0, {K1, 12'h0, 4'd7}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd7}, 1'b1, 1'b1);
        check("R11 safe wins", {28'b0, tgt_mode}, 32'd2);
        check("R11 safe pulse", {31'b0, req_valid}, 32'd1);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd7}, 1'b0, 1'b0);
        check("R11 sequence cancelled", {28'b0, tgt_mode}, 32'd2);
        rd(4'h8, r); check("R11 status clean", r, 32'h0);
        exp_tgt = 4'd2;

        // R11 wake beats the closing write
        swreq(4'd8);
        step(1'b1, 4'h0, {K1, 12'h0, 4'd5}, 1'b0, 1'b0);
        step(1'b1, 4'h0, {K2, 12'h0, 4'd5}, 1'b0, 1'b1);
        check("R11 wake wins", {28'b0, tgt_mode}, {28'b0, exp_last});
        rd(4'h8, r); check("R11 status after wake", r, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule